// File: doc/BRIEF.md
# Instruction prefetch queue controller

This block keeps a short byte-wide instruction queue topped up by running fetch cycles on a 16-bit external bus during the cycles when the CPU core has no data transfer of its own. A fetch program counter tracks the next byte to bring in. The alignment of that counter sets the kind of each cycle. An even counter gives a whole aligned word, which queues the even byte first and then the odd byte. An odd counter, as after a jump, gives a single odd byte. After that, the fetch stream goes on in whole words.

Each fetch cycle drives the byte address, an active-low high-byte enable and the A0 line. The cycle ends when the bus strobe falls. The core pops one byte per clock through a valid/data pair. On a jump it pulses a flush together with the new target address. The flush empties the queue in one cycle and drops any fetch still waiting for its strobe. The core asks for the bus with a request line. It is granted once no fetch is running, and new fetches hold off while the request stays high.

Top module: `ifetch_queue`

## Requirements
- R1: In reset and in the first cycle after reset, pop_valid_o, bus_fetch_o and cpu_bus_gnt_o are 0 and bus_bhe_n_o is 1. The first fetch after reset uses address RESET_ADDR (default 0x0000).
- R2: A fetch from an even address drives bus_bhe_n_o=0 and bus_a0_o=0 with bus_addr_o equal to that address. It queues bus_data_i[7:0] (even byte) and then bus_data_i[15:8] (odd byte), in that order.
- R3: A fetch from an odd address drives bus_bhe_n_o=0 and bus_a0_o=1. It queues only bus_data_i[15:8], and the following fetch uses the next, even, address as a word fetch.
- R4: A fetch cycle starts only in a cycle where no fetch is running, the queue has at least two free byte slots, cpu_bus_req_i is 0 and flush_i is 0. With one or zero free slots, no fetch starts.
- R5: A running fetch completes only at a clock edge where bus_e_i was 1 at the previous edge and is 0 at this edge. Until then, bus_fetch_o and bus_addr_o hold steady and nothing is queued.
- R6: pop_valid_o is 1 exactly when the queue holds a byte, and pop_data_o is the oldest byte. A pop_i at an edge with pop_valid_o=1 removes that byte, and one byte can be removed per clock. A pop_i while the queue is empty has no effect.
- R7: At the edge after flush_i=1, the queue is empty and no fetch is running. A fetch still waiting for its strobe is dropped and its data is never queued. The next fetch uses flush_addr_i.
- R8: cpu_bus_gnt_o is 1 when cpu_bus_req_i is 1 and no fetch is running. A fetch already running when the request rises finishes and queues its data, and the grant follows at the next cycle.
- R9: The fetch address advances by 1 after an odd-byte fetch and by 2 after a word fetch, wrapping modulo 2^16. Popped bytes therefore arrive in consecutive address order from the flush target, including across 0xFFFF to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| flush_i | input | 1 | Empty the queue and restart fetching at flush_addr_i |
| flush_addr_i | input | 16 | Jump target byte address |
| cpu_bus_req_i | input | 1 | Core wants the bus for a data cycle |
| cpu_bus_gnt_o | output | 1 | Bus handed to the core |
| pop_i | input | 1 | Core removes the oldest queued byte |
| pop_valid_o | output | 1 | Queue holds at least one byte |
| pop_data_o | output | 8 | Oldest queued byte |
| bus_fetch_o | output | 1 | A fetch cycle is running on the bus |
| bus_addr_o | output | 16 | Byte address of the running fetch |
| bus_bhe_n_o | output | 1 | High-byte enable, active low |
| bus_a0_o | output | 1 | Address bit 0 of the running fetch |
| bus_e_i | input | 1 | Bus strobe, transfer completes on its fall |
| bus_data_i | input | 16 | Read data, even byte on bits 7:0, odd byte on bits 15:8 |

## Verification
The hardest case to reach from the ports is a flush that lands while a fetch is still waiting for its strobe. In that case the stale word must never reach the queue. The bench reaches it by holding its bus responder stalled with the strobe high, so the cycle stays open. It then flushes and compares the first popped byte against the target's content rather than the stale address. The two-free-slot rule is reached by letting the queue fill with no pops and then popping single bytes while counting fetch starts. The running-fetch priority case is reached by raising the core's request in the middle of a stalled cycle.

// File: rtl/pfq_pkg.sv
// Package: shared types and widths of the prefetch queue controller.
// Assumes a 16-bit bus made of two byte lanes, even byte on the low lane.
package pfq_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    // Fetch sequencer state.
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_BUSY = 1'b1
    } fetch_state_t;

    // Kind of the running fetch cycle.
    typedef enum logic {
        KIND_WORD = 1'b0,
        KIND_ODD  = 1'b1
    } fetch_kind_t;
endpackage

// File: rtl/pfq_strobe_edge.sv
// Module: detects the completing edge of the bus strobe.
// Assumes bus_e_i is synchronous to clk. The fall is reported in the cycle
// where the strobe is low and was high at the previous edge.
module pfq_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic fall_o
);
    logic strobe_q;

    // Remember the strobe level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= strobe_i;
        end
    end

    // A fall is high-then-low across one edge.
    always_comb begin
        fall_o = strobe_q & ~strobe_i;
    end
endmodule

// File: rtl/pfq_byte_queue.sv
// Module: byte-wide circular queue that accepts one or two bytes and
// releases one byte per clock.
// Assumes DEPTH is a power of two (the pointers wrap by overflow) and that
// the writer never pushes more bytes than there are free slots.
module pfq_byte_queue #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic [1:0]                   push_n_i,
    input  logic [pfq_pkg::BYTE_W-1:0]   push_b0_i,
    input  logic [pfq_pkg::BYTE_W-1:0]   push_b1_i,
    input  logic                         pop_i,
    output logic                         valid_o,
    output logic [pfq_pkg::BYTE_W-1:0]   data_o,
    output logic [$clog2(DEPTH+1)-1:0]   free_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [pfq_pkg::BYTE_W-1:0] slots [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] fill;
    logic          pop_ok;

    // A pop counts only when a byte is present.
    always_comb begin
        pop_ok = pop_i && (fill != '0);
    end

    // Pointer and fill-level bookkeeping; a clear wins over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else if (clear_i) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            fill   <= '0;
        end else begin
            wr_ptr <= wr_ptr + PW'(push_n_i);
            if (pop_ok) begin
                rd_ptr <= rd_ptr + PW'(1);
            end
            fill <= fill + CW'(push_n_i) - CW'(pop_ok);
        end
    end

    // Byte storage: first byte at the write pointer, second one after it.
    always_ff @(posedge clk) begin
        if (!clear_i && (push_n_i != 2'd0)) begin
            slots[wr_ptr] <= push_b0_i;
            if (push_n_i == 2'd2) begin
                slots[wr_ptr + PW'(1)] <= push_b1_i;
            end
        end
    end

    // Head byte, presence flag and free slot count.
    always_comb begin
        data_o  = slots[rd_ptr];
        valid_o = (fill != '0);
        free_o  = CW'(DEPTH) - fill;
    end
endmodule

// File: rtl/pfq_fetch_seq.sv
// Module: fetch sequencer. It holds the fetch program counter, decides when
// a fetch may start, picks a word or odd-byte cycle from address bit 0,
// drives the bus and hands the captured bytes to the queue.
// Assumes free_i counts queue slots that are vacant now. Because a fetch
// only starts with two free slots and pops only add room, a completing
// fetch always fits.
module pfq_fetch_seq #(
    parameter int                 AW         = 16,
    parameter int                 DEPTH      = 4,
    parameter logic [AW-1:0]      RESET_ADDR = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush_i,
    input  logic [AW-1:0]                 flush_addr_i,
    input  logic                          cpu_bus_req_i,
    output logic                          cpu_bus_gnt_o,
    input  logic [$clog2(DEPTH+1)-1:0]    free_i,
    input  logic                          strobe_fall_i,
    input  logic [pfq_pkg::WORD_W-1:0]    bus_data_i,
    output logic                          bus_fetch_o,
    output logic [AW-1:0]                 bus_addr_o,
    output logic                          bus_bhe_n_o,
    output logic                          bus_a0_o,
    output logic [1:0]                    push_n_o,
    output logic [pfq_pkg::BYTE_W-1:0]    push_b0_o,
    output logic [pfq_pkg::BYTE_W-1:0]    push_b1_o
);
    import pfq_pkg::*;

    localparam int CW = $clog2(DEPTH+1);

    fetch_state_t  state;
    fetch_kind_t   kind;
    logic [AW-1:0] fetch_pc;
    logic [AW-1:0] cyc_addr;
    logic          start;
    logic          done;

    // Start and completion conditions of a fetch cycle.
    always_comb begin
        start = (state == FS_IDLE) && !flush_i && !cpu_bus_req_i
                && (free_i >= CW'(2));
        done  = (state == FS_BUSY) && !flush_i && strobe_fall_i;
    end

    // Sequencer state, cycle address and fetch program counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= FS_IDLE;
            kind     <= KIND_WORD;
            fetch_pc <= RESET_ADDR;
            cyc_addr <= RESET_ADDR;
        end else if (flush_i) begin
            state    <= FS_IDLE;
            fetch_pc <= flush_addr_i;
        end else if (start) begin
            state    <= FS_BUSY;
            cyc_addr <= fetch_pc;
            kind     <= fetch_pc[0] ? KIND_ODD : KIND_WORD;
        end else if (done) begin
            state    <= FS_IDLE;
            fetch_pc <= cyc_addr + ((kind == KIND_WORD) ? AW'(2) : AW'(1));
        end
    end

    // Lane steering of captured data toward the queue.
    always_comb begin
        push_n_o  = 2'd0;
        push_b0_o = bus_data_i[BYTE_W-1:0];
        push_b1_o = bus_data_i[WORD_W-1:BYTE_W];
        if (done) begin
            if (kind == KIND_WORD) begin
                push_n_o = 2'd2;
            end else begin
                push_n_o  = 2'd1;
                push_b0_o = bus_data_i[WORD_W-1:BYTE_W];
            end
        end
    end

    // Bus pins of the running cycle and the grant to the core.
    always_comb begin
        bus_fetch_o   = (state == FS_BUSY);
        bus_addr_o    = cyc_addr;
        bus_a0_o      = cyc_addr[0];
        bus_bhe_n_o   = (state != FS_BUSY);
        cpu_bus_gnt_o = cpu_bus_req_i && (state == FS_IDLE);
    end
endmodule

// File: rtl/ifetch_queue.sv
// Module: top of the instruction prefetch queue controller. It ties the
// strobe edge detector, the fetch sequencer and the byte queue together.
// Assumes all inputs are synchronous to clk and DEPTH is a power of two >= 2.
module ifetch_queue #(
    parameter int             AW         = 16,
    parameter int             DEPTH      = 4,
    parameter logic [AW-1:0]  RESET_ADDR = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic [AW-1:0]               flush_addr_i,
    input  logic                        cpu_bus_req_i,
    output logic                        cpu_bus_gnt_o,
    input  logic                        pop_i,
    output logic                        pop_valid_o,
    output logic [pfq_pkg::BYTE_W-1:0]  pop_data_o,
    output logic                        bus_fetch_o,
    output logic [AW-1:0]               bus_addr_o,
    output logic                        bus_bhe_n_o,
    output logic                        bus_a0_o,
    input  logic                        bus_e_i,
    input  logic [pfq_pkg::WORD_W-1:0]  bus_data_i
);
    localparam int CW = $clog2(DEPTH+1);

    logic                       e_fall;
    logic [CW-1:0]              q_free;
    logic [1:0]                 push_n;
    logic [pfq_pkg::BYTE_W-1:0] push_b0;
    logic [pfq_pkg::BYTE_W-1:0] push_b1;

    pfq_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (bus_e_i),
        .fall_o   (e_fall)
    );

    pfq_fetch_seq #(
        .AW         (AW),
        .DEPTH      (DEPTH),
        .RESET_ADDR (RESET_ADDR)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .flush_addr_i  (flush_addr_i),
        .cpu_bus_req_i (cpu_bus_req_i),
        .cpu_bus_gnt_o (cpu_bus_gnt_o),
        .free_i        (q_free),
        .strobe_fall_i (e_fall),
        .bus_data_i    (bus_data_i),
        .bus_fetch_o   (bus_fetch_o),
        .bus_addr_o    (bus_addr_o),
        .bus_bhe_n_o   (bus_bhe_n_o),
        .bus_a0_o      (bus_a0_o),
        .push_n_o      (push_n),
        .push_b0_o     (push_b0),
        .push_b1_o     (push_b1)
    );

    pfq_byte_queue #(
        .DEPTH (DEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_i),
        .push_n_i  (push_n),
        .push_b0_i (push_b0),
        .push_b1_i (push_b1),
        .pop_i     (pop_i),
        .valid_o   (pop_valid_o),
        .data_o    (pop_data_o),
        .free_o    (q_free)
    );
endmodule

// File: rtl/pfq_checker.sv
// Module: assertion checker for ifetch_queue, attached by bind.
// Keeps its own model of the expected next fetch address.
module pfq_checker #(
    parameter int             AW         = 16,
    parameter int             DEPTH      = 4,
    parameter logic [AW-1:0]  RESET_ADDR = '0
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        flush_i,
    input logic [AW-1:0]               flush_addr_i,
    input logic                        cpu_bus_req_i,
    input logic                        cpu_bus_gnt_o,
    input logic                        pop_valid_o,
    input logic                        bus_fetch_o,
    input logic [AW-1:0]               bus_addr_o,
    input logic                        bus_bhe_n_o,
    input logic                        bus_e_i,
    input logic [$clog2(DEPTH+1)-1:0]  free_slots
);
    logic          e_q;
    logic [AW-1:0] exp_next;

    // Model of where the next fetch must begin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q      <= 1'b0;
            exp_next <= RESET_ADDR;
        end else begin
            e_q <= bus_e_i;
            if (flush_i) begin
                exp_next <= flush_addr_i;
            end else if (bus_fetch_o && e_q && !bus_e_i) begin
                exp_next <= bus_addr_o + (bus_addr_o[0] ? AW'(1) : AW'(2));
            end
        end
    end

    assert_enable_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fetch_o) |-> !bus_bhe_n_o);

    assert_start_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fetch_o) |-> ($past(free_slots) >= 2 && !$past(cpu_bus_req_i)
                                && !$past(flush_i)));

    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_fetch_o && $past(bus_fetch_o)) |-> $stable(bus_addr_o));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush_i) |-> (!pop_valid_o && !bus_fetch_o));

    assert_grant_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_bus_gnt_o && bus_fetch_o));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_fetch_o) |-> (bus_addr_o == exp_next));
endmodule

bind ifetch_queue pfq_checker #(
    .AW         (AW),
    .DEPTH      (DEPTH),
    .RESET_ADDR (RESET_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush_i       (flush_i),
    .flush_addr_i  (flush_addr_i),
    .cpu_bus_req_i (cpu_bus_req_i),
    .cpu_bus_gnt_o (cpu_bus_gnt_o),
    .pop_valid_o   (pop_valid_o),
    .bus_fetch_o   (bus_fetch_o),
    .bus_addr_o    (bus_addr_o),
    .bus_bhe_n_o   (bus_bhe_n_o),
    .bus_e_i       (bus_e_i),
    .free_slots    (q_free)
);

// File: tb/tb_ifetch_queue.sv
// Bench: memory-model bus responder, a table of flush/pop-stream vectors,
// then directed tests for reset, cancellation, room and priority.
module tb_ifetch_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_addr_i = '0;
    logic        cpu_bus_req_i = 1'b0;
    logic        cpu_bus_gnt_o;
    logic        pop_i = 1'b0;
    logic        pop_valid_o;
    logic [7:0]  pop_data_o;
    logic        bus_fetch_o;
    logic [15:0] bus_addr_o;
    logic        bus_bhe_n_o;
    logic        bus_a0_o;
    logic        bus_e_i = 1'b1;
    logic [15:0] bus_data_i = '0;

    int checks = 0;
    int failures = 0;
    int starts = 0;
    bit resp_en = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ifetch_queue dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .flush_addr_i  (flush_addr_i),
        .cpu_bus_req_i (cpu_bus_req_i),
        .cpu_bus_gnt_o (cpu_bus_gnt_o),
        .pop_i         (pop_i),
        .pop_valid_o   (pop_valid_o),
        .pop_data_o    (pop_data_o),
        .bus_fetch_o   (bus_fetch_o),
        .bus_addr_o    (bus_addr_o),
        .bus_bhe_n_o   (bus_bhe_n_o),
        .bus_a0_o      (bus_a0_o),
        .bus_e_i       (bus_e_i),
        .bus_data_i    (bus_data_i)
    );

    // Flush target and number of bytes to pop from it.
    localparam logic [23:0] VECS [6] = '{
        {16'h0000, 8'd6}, {16'h0031, 8'd5}, {16'h1FFF, 8'd9},
        {16'h0102, 8'd7}, {16'hFFFF, 8'd4}, {16'h0AB7, 8'd3}
    };

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_flush(input logic [15:0] a);
        flush_addr_i = a;
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic wait_fetch(input bit level);
        for (int i = 0; i < 50 && bus_fetch_o != level; i++) @(negedge clk);
    endtask

    // Pop n bytes in order and compare each with the memory model.
    task automatic pop_seq(input logic [15:0] a, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            for (int w = 0; w < 60 && !pop_valid_o; w++) @(negedge clk);
            check(pop_valid_o && pop_data_o == mem_byte(a + 16'(i)), tag,
                  pop_data_o, mem_byte(a + 16'(i)));
            pop_i = 1'b1;
            @(negedge clk);
            pop_i = 1'b0;
        end
    endtask

    // Bus responder: strobe falls on the second cycle of a fetch.
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || !bus_fetch_o || !resp_en) begin
                bus_e_i = 1'b1;
                cnt = 0;
            end else begin
                cnt++;
                if (cnt >= 2) begin
                    bus_e_i = 1'b0;
                    bus_data_i = {mem_byte({bus_addr_o[15:1], 1'b1}),
                                  mem_byte({bus_addr_o[15:1], 1'b0})};
                end
            end
        end
    end

    // Fetch start counter.
    initial begin
        bit prev = 1'b0;
        forever begin
            @(negedge clk);
            if (bus_fetch_o && !prev) starts++;
            prev = bus_fetch_o;
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0;
        wait_cycles(3);
        // R1: reset state
        check(!pop_valid_o && !bus_fetch_o && bus_bhe_n_o && !cpu_bus_gnt_o,
              "R1 reset outputs", {pop_valid_o, bus_fetch_o, bus_bhe_n_o}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R2: first fetch from RESET_ADDR as a word
        check(bus_fetch_o && bus_addr_o == 16'h0000 && !bus_a0_o && !bus_bhe_n_o,
              "R1 R2 first fetch", bus_addr_o, 16'h0000);
        wait_cycles(3);
        // R5: strobe held high, no completion
        check(bus_fetch_o && bus_addr_o == 16'h0000 && !pop_valid_o,
              "R5 stalled fetch held", {bus_fetch_o, pop_valid_o}, 2'b10);
        // R7: flush cancels the open cycle
        bus_data_i = 16'hDEAD;
        do_flush(16'h0040);
        check(!bus_fetch_o && !pop_valid_o, "R7 flush clears",
              {bus_fetch_o, pop_valid_o}, 2'b00);
        resp_en = 1'b1;
        pop_seq(16'h0040, 3, "R7 target data");

        // Table walk: R9 byte order from each target
        foreach (VECS[k]) begin
            do_flush(VECS[k][23:8]);
            pop_seq(VECS[k][23:8], int'(VECS[k][7:0]), "R9 stream order");
        end

        // R4: full queue stops fetching; one free slot is not enough
        do_flush(16'h0200);
        wait_cycles(20);
        check(!bus_fetch_o && pop_valid_o, "R4 full queue idle",
              {bus_fetch_o, pop_valid_o}, 2'b01);
        pop_seq(16'h0200, 1, "R6 head byte");
        s0 = starts;
        wait_cycles(10);
        check(starts == s0, "R4 one free slot no fetch", starts, s0);
        pop_seq(16'h0201, 1, "R6 second byte");
        wait_cycles(10);
        check(starts == s0 + 1, "R4 two free slots fetch", starts, s0 + 1);
        pop_seq(16'h0202, 6, "R2 word order");

        // R3: odd target, single byte then word, then queue at 3 bytes
        resp_en = 1'b0;
        do_flush(16'h0301);
        wait_fetch(1'b1);
        check(bus_addr_o == 16'h0301 && bus_a0_o && !bus_bhe_n_o,
              "R3 odd fetch pins", bus_addr_o, 16'h0301);
        resp_en = 1'b1;
        wait_fetch(1'b0);
        wait_fetch(1'b1);
        check(bus_addr_o == 16'h0302 && !bus_a0_o && !bus_bhe_n_o,
              "R3 R9 word after odd", bus_addr_o, 16'h0302);
        s0 = starts;
        wait_cycles(20);
        check(starts == s0 && !bus_fetch_o, "R4 three bytes held", starts, s0);
        pop_seq(16'h0301, 5, "R3 odd stream");

        // R8: request before any fetch blocks prefetch
        flush_addr_i = 16'h0400;
        flush_i = 1'b1;
        cpu_bus_req_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        s0 = starts;
        wait_cycles(8);
        check(starts == s0 && cpu_bus_gnt_o && !pop_valid_o, "R8 request blocks",
              {cpu_bus_gnt_o, pop_valid_o}, 2'b10);
        cpu_bus_req_i = 1'b0;
        pop_seq(16'h0400, 2, "R8 resume");

        // R8: a running fetch finishes before the grant
        resp_en = 1'b0;
        do_flush(16'h0500);
        wait_fetch(1'b1);
        cpu_bus_req_i = 1'b1;
        @(negedge clk);
        check(!cpu_bus_gnt_o && bus_fetch_o, "R8 no grant mid fetch",
              cpu_bus_gnt_o, 0);
        resp_en = 1'b1;
        wait_fetch(1'b0);
        check(cpu_bus_gnt_o && pop_valid_o, "R8 grant after fetch",
              {cpu_bus_gnt_o, pop_valid_o}, 2'b11);
        s0 = starts;
        wait_cycles(5);
        check(starts == s0, "R8 no new fetch", starts, s0);
        cpu_bus_req_i = 1'b0;
        pop_seq(16'h0500, 4, "R8 finished data");

        // R6: pop on an empty queue is ignored
        resp_en = 1'b0;
        do_flush(16'h0600);
        pop_i = 1'b1;
        wait_cycles(3);
        check(!pop_valid_o, "R6 empty pop", pop_valid_o, 0);
        pop_i = 1'b0;
        resp_en = 1'b1;
        pop_seq(16'h0600, 3, "R6 first byte intact");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule